// File: doc/BRIEF.md
# Integer Register Rename Table with Flag Groups

This block is the register alias table of a small out-of-order integer core. Each physical register entry is wide enough to hold a 64-bit integer result together with the flags produced by the same instruction, so an instruction that writes a general-purpose register and flags takes one physical tag for both. The table holds one mapping for each of the 16 architectural integer registers. It holds two more mappings for flag state: one for the carry flag alone and one for the group of sign, parity, adjust, zero and overflow flags. Segment registers are not mapped here.

In each cycle one instruction can be presented with two source register numbers, an optional destination and a two-bit flag-write mask. In the same cycle the table returns the source tags, the current tags of both flag groups, the tag the destination mapping held before, and the tag it would allocate. If the instruction writes anything and is accepted, the table takes the lowest-numbered free tag and points each written mapping at it. A commit port moves retiring results into a committed copy of the map. A tag returns to the pool once nothing in flight and no committed mapping still uses it. A flush copies the committed map back into the speculative map and drops all in-flight allocations, so no checkpoints are needed.

Top module: `int_rename_table`

## Requirements
- R1: After reset, architectural register i maps to tag i, both flag groups map to tag 16, and the first tag offered is 17 (default 16 registers, 32 tags).
- R2: Source tags are read from the mapping before the instruction's own update, so an instruction that reads and writes the same register gets the older tag.
- R3: An accepted instruction with a destination or any flag-write bit is given the lowest-numbered free tag, and every mapping it writes points at that tag from the next cycle on.
- R4: Flag-write bit 0 selects the carry group and bit 1 the other arithmetic flag group. Only the selected groups are remapped, and an unselected group keeps its older tag.
- R5: An accepted instruction that writes flags but has no destination still takes one tag and leaves every general-purpose mapping unchanged.
- R6: The previous-destination output gives the tag the destination register held before the instruction.
- R7: Ready is low when no tag is free or a flush is requested. While ready is low, a valid instruction changes no mapping and allocates nothing.
- R8: An accepted instruction with no destination and an all-zero flag mask allocates no tag and changes no mapping.
- R9: A committed tag leaves the in-flight set. Any tag that no committed mapping and no in-flight instruction uses is free again one cycle later.
- R10: A flush makes the speculative map equal to the committed map, including a commit in the same cycle, and frees every tag still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rn_valid | input | 1 | Rename request valid |
| rn_ready | output | 1 | Rename can accept (a tag is free and no flush) |
| rn_src_a | input | 4 | First source register number |
| rn_src_b | input | 4 | Second source register number |
| rn_dst_en | input | 1 | Instruction has a general-purpose destination |
| rn_dst | input | 4 | Destination register number |
| rn_flag_wr | input | 2 | Flag groups written: bit 0 carry, bit 1 other arithmetic flags |
| rn_src_a_tag | output | 5 | Tag currently mapped to rn_src_a |
| rn_src_b_tag | output | 5 | Tag currently mapped to rn_src_b |
| rn_carry_tag | output | 5 | Tag currently supplying the carry flag; also its previous tag |
| rn_arith_tag | output | 5 | Tag currently supplying the other flag group; also its previous tag |
| rn_prev_dst_tag | output | 5 | Tag rn_dst maps to before this instruction |
| rn_new_tag | output | 5 | Tag given to an accepted instruction this cycle |
| cm_valid | input | 1 | Commit of one allocating instruction, oldest first |
| cm_dst_en | input | 1 | Committing instruction had a destination |
| cm_dst | input | 4 | Committing instruction's destination register |
| cm_flag_wr | input | 2 | Committing instruction's flag mask, same encoding as rn_flag_wr |
| cm_tag | input | 5 | Tag that was given to the committing instruction |
| flush | input | 1 | Discard speculative state and return to the committed map |

## Verification
Rename and commit often happen in the same cycle. Commit changes which tags are referenced, and rename picks its tag from the pool as it stood before the edge. The bench drives long mixed sequences in which commits of the oldest in-flight instruction overlap with new renames. It predicts every tag and ready value from a model of the committed map, the speculative map and the in-flight set. A flush is also issued in the same cycle as a commit, and the restored map is judged by reading every register back through the source ports.

// File: rtl/irt_pkg.sv
package irt_pkg;
   localparam int FLAG_GROUPS = 2;
   localparam int FLG_CARRY   = 0;   // carry flag alone
   localparam int FLG_ARITH   = 1;   // sign/parity/adjust/zero/overflow group
endpackage

// File: rtl/irt_map_bank.sv
module irt_map_bank #(
   parameter int SLOTS    = 18,
   parameter int NUM_ARCH = 16,
   parameter int TW       = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SLOTS-1:0]    wr_en,
   input  logic [TW-1:0]       wr_tag,
   input  logic                load_en,
   input  logic [SLOTS*TW-1:0] load_map,
   output logic [SLOTS*TW-1:0] map_q
);
   generate
      if (SLOTS <= NUM_ARCH) begin : g_bad_slots
         $error("irt_map_bank: SLOTS must exceed NUM_ARCH");
      end
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         // GP slots start on their own index, flag slots share the first spare tag
         localparam int INIT_I = (s < NUM_ARCH) ? s : NUM_ARCH;
         logic [TW-1:0] slot_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               slot_q <= TW'(INIT_I);
            else if (load_en)
               slot_q <= load_map[s*TW +: TW];
            else if (wr_en[s])
               slot_q <= wr_tag;
         end
         assign map_q[s*TW +: TW] = slot_q;
      end
   endgenerate
endmodule

// File: rtl/irt_free_pool.sv
module irt_free_pool #(
   parameter int NUM_PHYS = 32,
   parameter int SLOTS    = 18,
   parameter int TW       = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SLOTS*TW-1:0] cmt_map,
   input  logic                alloc_en,
   output logic                avail,
   output logic [TW-1:0]       alloc_tag,
   input  logic                release_en,
   input  logic [TW-1:0]       release_tag,
   input  logic                flush
);
   logic [NUM_PHYS-1:0] inflight_q, inflight_d;
   logic [NUM_PHYS-1:0] referenced;
   logic [NUM_PHYS-1:0] free_vec;

   generate
      if ((1 << TW) != NUM_PHYS) begin : g_bad_tw
         $error("irt_free_pool: NUM_PHYS must equal 2**TW");
      end
   endgenerate

   // tags still named by the committed map are held
   always_comb begin
      referenced = '0;
      for (int s = 0; s < SLOTS; s++)
         referenced[cmt_map[s*TW +: TW]] = 1'b1;
   end

   assign free_vec = ~referenced & ~inflight_q;

   // lowest-index free tag
   always_comb begin
      alloc_tag = '0;
      for (int t = NUM_PHYS - 1; t >= 0; t--)
         if (free_vec[t]) alloc_tag = TW'(t);
   end
   assign avail = |free_vec;

   always_comb begin
      inflight_d = inflight_q;
      if (release_en) inflight_d[release_tag] = 1'b0;
      if (alloc_en)   inflight_d[alloc_tag]   = 1'b1;
      if (flush)      inflight_d = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) inflight_q <= '0;
      else        inflight_q <= inflight_d;
   end

   // R9: only an in-flight tag may be committed
   p_commit_inflight_r9: assert property (@(posedge clk) disable iff (!rst_n)
      release_en |-> inflight_q[release_tag]);
   // R7: no allocation without a free tag
   p_alloc_needs_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> avail);
   // R3: an allocated tag is in flight on the next cycle unless flushed
   p_alloc_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_en && !flush) |=> inflight_q[$past(alloc_tag)]);
endmodule

// File: rtl/int_rename_table.sv
module int_rename_table
   import irt_pkg::*;
#(
   parameter int NUM_ARCH = 16,
   parameter int NUM_PHYS = 32,
   localparam int AW = $clog2(NUM_ARCH),
   localparam int TW = $clog2(NUM_PHYS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rn_valid,
   output logic          rn_ready,
   input  logic [AW-1:0] rn_src_a,
   input  logic [AW-1:0] rn_src_b,
   input  logic          rn_dst_en,
   input  logic [AW-1:0] rn_dst,
   input  logic [1:0]    rn_flag_wr,
   output logic [TW-1:0] rn_src_a_tag,
   output logic [TW-1:0] rn_src_b_tag,
   output logic [TW-1:0] rn_carry_tag,
   output logic [TW-1:0] rn_arith_tag,
   output logic [TW-1:0] rn_prev_dst_tag,
   output logic [TW-1:0] rn_new_tag,
   input  logic          cm_valid,
   input  logic          cm_dst_en,
   input  logic [AW-1:0] cm_dst,
   input  logic [1:0]    cm_flag_wr,
   input  logic [TW-1:0] cm_tag,
   input  logic          flush
);
   localparam int SLOTS   = NUM_ARCH + FLAG_GROUPS;
   localparam int CF_SLOT = NUM_ARCH + FLG_CARRY;
   localparam int AR_SLOT = NUM_ARCH + FLG_ARITH;

   generate
      if (NUM_ARCH < 2 || (1 << AW) != NUM_ARCH) begin : g_bad_arch
         $error("int_rename_table: NUM_ARCH must be a power of two >= 2");
      end
      if (NUM_PHYS <= SLOTS) begin : g_bad_phys
         $error("int_rename_table: NUM_PHYS must exceed the mapping count");
      end
   endgenerate

   logic [SLOTS*TW-1:0] spec_flat, cmt_flat, cmt_next;
   logic [SLOTS-1:0]    spec_we, cmt_we;
   logic [TW-1:0]       gp_tag [NUM_ARCH];
   logic                need_alloc, fire, pool_avail;
   logic [TW-1:0]       pool_tag;

   always_comb
      for (int s = 0; s < NUM_ARCH; s++)
         gp_tag[s] = spec_flat[s*TW +: TW];

   assign need_alloc = rn_dst_en | (|rn_flag_wr);
   assign rn_ready   = pool_avail & ~flush;
   assign fire       = rn_valid & rn_ready & need_alloc;

   generate
      for (genvar g = 0; g < NUM_ARCH; g++) begin : g_gp_we
         assign spec_we[g] = fire & rn_dst_en & (rn_dst == AW'(g));
         assign cmt_we[g]  = cm_valid & cm_dst_en & (cm_dst == AW'(g));
      end
   endgenerate
   assign spec_we[CF_SLOT] = fire & rn_flag_wr[FLG_CARRY];
   assign spec_we[AR_SLOT] = fire & rn_flag_wr[FLG_ARITH];
   assign cmt_we[CF_SLOT]  = cm_valid & cm_flag_wr[FLG_CARRY];
   assign cmt_we[AR_SLOT]  = cm_valid & cm_flag_wr[FLG_ARITH];

   // committed map as it stands after this cycle's commit; source for flush
   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_cmt_next
         assign cmt_next[s*TW +: TW] = cmt_we[s] ? cm_tag : cmt_flat[s*TW +: TW];
      end
   endgenerate

   irt_map_bank #(.SLOTS(SLOTS), .NUM_ARCH(NUM_ARCH), .TW(TW)) u_spec (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (spec_we),
      .wr_tag   (pool_tag),
      .load_en  (flush),
      .load_map (cmt_next),
      .map_q    (spec_flat)
   );

   irt_map_bank #(.SLOTS(SLOTS), .NUM_ARCH(NUM_ARCH), .TW(TW)) u_cmt (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cmt_we),
      .wr_tag   (cm_tag),
      .load_en  (1'b0),
      .load_map ({(SLOTS*TW){1'b0}}),
      .map_q    (cmt_flat)
   );

   irt_free_pool #(.NUM_PHYS(NUM_PHYS), .SLOTS(SLOTS), .TW(TW)) u_pool (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmt_map     (cmt_flat),
      .alloc_en    (fire),
      .avail       (pool_avail),
      .alloc_tag   (pool_tag),
      .release_en  (cm_valid),
      .release_tag (cm_tag),
      .flush       (flush)
   );

   assign rn_src_a_tag    = gp_tag[rn_src_a];
   assign rn_src_b_tag    = gp_tag[rn_src_b];
   assign rn_prev_dst_tag = gp_tag[rn_dst];
   assign rn_carry_tag    = spec_flat[CF_SLOT*TW +: TW];
   assign rn_arith_tag    = spec_flat[AR_SLOT*TW +: TW];
   assign rn_new_tag      = pool_tag;

   // R2: a self-dependent instruction never reads its own new tag
   p_self_read_old_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && rn_dst_en && rn_src_a == rn_dst) |-> (rn_src_a_tag != rn_new_tag));
   // R3: destination points at the allocated tag afterwards
   p_dst_takes_new_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && rn_dst_en) |=> (gp_tag[$past(rn_dst)] == $past(rn_new_tag)));
   // R5: a flag-only instruction leaves every GP mapping alone
   p_flag_only_gp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !rn_dst_en) |=> $stable(spec_flat[NUM_ARCH*TW-1:0]));
   // R7: a stalled request changes no mapping
   p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rn_valid && !rn_ready && !flush) |=> $stable(spec_flat));
   // R10: after a flush the speculative map equals the committed one
   p_flush_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (spec_flat == cmt_flat));
endmodule

// File: tb/int_rename_table_bench.sv
`timescale 1ns/1ps
module int_rename_table_bench;
   localparam int NA = 16;
   localparam int NP = 32;
   localparam int NS = NA + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rn_valid = 1'b0, rn_dst_en = 1'b0, cm_valid = 1'b0, cm_dst_en = 1'b0, flush = 1'b0;
   logic [3:0] rn_src_a = '0, rn_src_b = '0, rn_dst = '0, cm_dst = '0;
   logic [1:0] rn_flag_wr = '0, cm_flag_wr = '0;
   logic [4:0] cm_tag = '0;
   logic rn_ready;
   logic [4:0] rn_src_a_tag, rn_src_b_tag, rn_carry_tag, rn_arith_tag, rn_prev_dst_tag, rn_new_tag;

   always #2.5 clk = ~clk;

   int_rename_table u_int_rename_table (
      .clk(clk), .rst_n(rst_n), .rn_valid(rn_valid), .rn_ready(rn_ready),
      .rn_src_a(rn_src_a), .rn_src_b(rn_src_b), .rn_dst_en(rn_dst_en), .rn_dst(rn_dst),
      .rn_flag_wr(rn_flag_wr), .rn_src_a_tag(rn_src_a_tag), .rn_src_b_tag(rn_src_b_tag),
      .rn_carry_tag(rn_carry_tag), .rn_arith_tag(rn_arith_tag),
      .rn_prev_dst_tag(rn_prev_dst_tag), .rn_new_tag(rn_new_tag),
      .cm_valid(cm_valid), .cm_dst_en(cm_dst_en), .cm_dst(cm_dst),
      .cm_flag_wr(cm_flag_wr), .cm_tag(cm_tag), .flush(flush));

   int n_run = 0, n_fail = 0;
   bit done = 0;
   int mspec [NS];
   int mcmt  [NS];
   bit minfl [NP];
   bit q_de [64]; int q_d [64]; int q_fw [64]; int q_tag [64];
   int q_h = 0, q_n = 0;
   logic [31:0] rs = 32'h1d87_2b41;

   task automatic chk(input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", what, act, exp);
      end
   endtask

   function automatic int lowest_free();
      for (int t = 0; t < NP; t++) begin
         bit used = minfl[t];
         for (int s = 0; s < NS; s++) if (mcmt[s] == t) used = 1;
         if (!used) return t;
      end
      return -1;
   endfunction

   function automatic logic [31:0] rnd();
      rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
      return rs;
   endfunction

   task automatic idle_inputs();
      rn_valid = 0; rn_dst_en = 0; rn_flag_wr = '0; cm_valid = 0; cm_dst_en = 0;
      cm_flag_wr = '0; flush = 0;
   endtask

   // one cycle: drive, predict, check, clock, update model
   task automatic step(input bit v, input int sa, input int sb, input bit de, input int d,
                       input int fw, input bit cmt, input bit fl);
      int lf; bit rdy; bit fire; bit dc;
      @(negedge clk);
      dc = cmt && (q_n > 0);
      rn_valid = v; rn_src_a = 4'(sa); rn_src_b = 4'(sb); rn_dst_en = de; rn_dst = 4'(d);
      rn_flag_wr = 2'(fw); flush = fl; cm_valid = dc;
      if (dc) begin
         cm_dst_en = q_de[q_h]; cm_dst = 4'(q_d[q_h]); cm_flag_wr = 2'(q_fw[q_h]);
         cm_tag = 5'(q_tag[q_h]);
      end
      #1;
      lf = lowest_free();
      rdy = (lf >= 0) && !fl;
      chk("R7 ready", rn_ready, rdy);
      if (lf >= 0) chk("R3 new tag", rn_new_tag, lf);
      chk("R2 src a tag", rn_src_a_tag, mspec[sa]);
      chk("R2 src b tag", rn_src_b_tag, mspec[sb]);
      chk("R6 prev dst tag", rn_prev_dst_tag, mspec[d]);
      chk("R4 carry tag", rn_carry_tag, mspec[NA]);
      chk("R4 arith tag", rn_arith_tag, mspec[NA+1]);
      fire = v && rdy && (de || fw != 0);
      @(posedge clk);
      if (dc) begin
         if (q_de[q_h]) mcmt[q_d[q_h]] = q_tag[q_h];
         if (q_fw[q_h][0]) mcmt[NA] = q_tag[q_h];
         if (q_fw[q_h][1]) mcmt[NA+1] = q_tag[q_h];
         minfl[q_tag[q_h]] = 0;
         q_h = (q_h + 1) % 64; q_n--;
      end
      if (fire) begin
         int tl = (q_h + q_n) % 64;
         if (de) mspec[d] = lf;
         if (fw[0]) mspec[NA] = lf;
         if (fw[1]) mspec[NA+1] = lf;
         minfl[lf] = 1;
         q_de[tl] = de; q_d[tl] = d; q_fw[tl] = fw; q_tag[tl] = lf; q_n++;
      end
      if (fl) begin
         for (int s = 0; s < NS; s++) mspec[s] = mcmt[s];
         for (int t = 0; t < NP; t++) minfl[t] = 0;
         q_n = 0;
      end
      #1;
      idle_inputs();
   endtask

   // read every GP mapping through the source port
   task automatic check_gp(input string what);
      for (int i = 0; i < NA; i++) begin
         @(negedge clk);
         rn_src_a = 4'(i);
         #1;
         chk(what, rn_src_a_tag, mspec[i]);
      end
      chk(what, rn_carry_tag, mspec[NA]);
      chk(what, rn_arith_tag, mspec[NA+1]);
   endtask

   initial begin
      int saved;
      idle_inputs();
      for (int s = 0; s < NS; s++) begin
         mspec[s] = (s < NA) ? s : NA;
         mcmt[s]  = mspec[s];
      end
      for (int t = 0; t < NP; t++) minfl[t] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;

      // R1: reset map and first offered tag
      check_gp("R1 reset map");
      @(negedge clk); #1;
      chk("R1 first free tag", rn_new_tag, 17);

      // R9: rename r3, commit it, the old tag 3 becomes free
      step(1, 0, 0, 1, 3, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 1, 0);
      @(negedge clk); #1;
      chk("R9 old r3 tag reused", rn_new_tag, 3);

      // R2: same register read and written
      step(1, 5, 5, 1, 5, 0, 0, 0);
      step(1, 5, 0, 0, 0, 0, 0, 0);
      // R4: carry-only update
      step(1, 0, 0, 0, 0, 1, 0, 0);
      @(negedge clk); #1;
      chk("R4 groups split", (rn_carry_tag == rn_arith_tag) ? 1 : 0, 0);
      // R5: flags-only instruction
      step(1, 0, 0, 0, 0, 3, 0, 0);
      check_gp("R5 GP map after flag-only");
      // R8: nothing to write, nothing allocated
      @(negedge clk); #1; saved = rn_new_tag;
      step(1, 2, 3, 0, 7, 0, 0, 0);
      @(negedge clk); #1;
      chk("R8 no allocation", rn_new_tag, saved);
      check_gp("R8 map unchanged");

      // R7: exhaust the pool, then try once more
      for (int i = 0; i < 20; i++) step(1, i % NA, 0, 1, i % NA, i % 4, 0, 0);
      @(negedge clk); #1;
      chk("R7 pool exhausted", rn_ready, 0);
      step(1, 2, 2, 1, 2, 3, 0, 0);
      check_gp("R7 stalled map");

      // R9: drain commits, pool refills
      while (q_n > 0) step(0, 0, 0, 0, 0, 0, 1, 0);
      @(negedge clk); #1;
      chk("R9 pool refilled", rn_ready, 1);

      // R10: flush in the same cycle as a commit
      step(1, 1, 2, 1, 9, 2, 0, 0);
      step(1, 9, 4, 1, 4, 1, 0, 0);
      step(1, 4, 9, 1, 11, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 1, 1);
      check_gp("R10 map after flush");
      @(negedge clk); #1;
      chk("R10 tags released", rn_new_tag, lowest_free());

      // mixed sweep with overlapping rename, commit and rare flush
      for (int k = 0; k < 4000; k++) begin
         logic [31:0] r;
         r = rnd();
         step(r[0] | r[1], int'(r[5:2]), int'(r[9:6]), r[10] | r[11], int'(r[15:12]),
              int'(r[17:16]), r[18] & (r[19] | r[20]), r[26:21] == 6'd0);
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule